// File: doc/BRIEF.md
# Synchronous SRAM Write and Read Datapath

This block is the data side of a synchronous static RAM built around a small memory array. Each clock edge accepts one command: a read, a write, or a deselect. The command comes from the active-low chip enable and the write controls. Writes update a byte-masked set of lanes. The mask comes from a global write strobe, or from a byte-write enable combined with per-byte selects. All write controls are active low. The address comes from an external burst sequencer and is used as presented.

Reads leave the block in one of two ways, selected at run time by a mode input. In flow-through mode the array output goes straight to the port in the cycle after the command edge. In pipelined mode it passes through an output register and appears one edge later. Deselects travel through the same stages as reads, so the last read beat stays on the port for one more cycle before the drive flag drops. The drive flag is also gated at once, without a clock, by an output enable and by a sleep input. Sleep also blocks writes, and the array keeps its contents while sleep is high.

Top module: `ssram_datapath`

## Requirements
- R1: With the global write `gw_ni` high and the byte-write enable `bwe_ni` low, a selected command writes only the byte lanes whose `bsel_ni` bit is low. Bit i maps to data bits [8i+7:8i]. The other lanes keep their contents.
- R2: A selected command with `gw_ni` low writes every byte lane, whatever `bwe_ni` and `bsel_ni` are.
- R3: A selected command with `gw_ni` high is a read when `bwe_ni` is high or all `bsel_ni` bits are high. The memory is unchanged.
- R4: With `pipe_i` low, a read command sampled at edge k drives its data, with `drive_o` high, from edge k until edge k+1.
- R5: With `pipe_i` high, a read command sampled at edge k drives nothing after edge k and drives its data after edge k+1.
- R6: Take a read at edge d-1 followed by a deselect (`en_ni` high) at edge d. In both modes the last read data stays driven after edge d, and `drive_o` is low after edge d+1 unless a new read takes over.
- R7: A write command puts no data on the output in its own output slot: after its edge in flow-through mode, and after the next edge in pipelined mode.
- R8: `oe_ni` high forces `drive_o` low and `rdata_o` to zero at once, with no clock edge. `oe_ni` low restores the pending output.
- R9: While `sleep_i` is high, `drive_o` is low at once, commands are taken as deselects and no write reaches the array. Stored data is kept. The first edge after release accepts a command.
- R10: While `rst_ni` is low, `drive_o` is low and `rdata_o` is zero.
- R11: Back-to-back reads deliver one new word per cycle in either mode. A read reflects every write sampled at an earlier edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Chip enable, active low; high is a deselect |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bsel_ni | input | BYTES | Per-byte selects, active low |
| addr_i | input | ADDR_W | Word address from burst sequencer |
| wdata_i | input | BYTES*BYTE_W | Write data |
| pipe_i | input | 1 | 0 flow-through, 1 registered output |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| rdata_o | output | BYTES*BYTE_W | Read data, zero when not driven |
| drive_o | output | 1 | Output drive / data valid |

## Verification
In pipelined mode a write command can be sampled on the same edge at which the registered output still shows an earlier read. The bench provokes this by writing, on that edge, the very address whose pipelined read is still in flight. It judges the result by requiring the old word on the port while `drive_o` stays high, and no drive in the following slot. A second overlap is between the asynchronous gates and a driven read beat. `oe_ni` and `sleep_i` are toggled in the middle of such a beat, and the output must drop before any clock edge arrives.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;
endpackage

// File: rtl/ssram_wr_decode.sv
module ssram_wr_decode
  import ssram_pkg::*;
#(
  parameter int unsigned BYTES = 2
) (
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [BYTES-1:0] bsel_ni,
  input  logic             sleep_i,
  output cmd_e             cmd_o,
  output logic [BYTES-1:0] be_o
);
  logic wr_any;

  assign wr_any = !gw_ni || (!bwe_ni && !(&bsel_ni));

  always_comb begin
    if (sleep_i || en_ni) cmd_o = CMD_IDLE;
    else if (wr_any)      cmd_o = CMD_WR;
    else                  cmd_o = CMD_RD;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_be
    assign be_o[b] = (cmd_o == CMD_WR) && (!gw_ni || (!bwe_ni && !bsel_ni[b]));
  end

  always_comb begin
    if (rst_ni && !sleep_i && !en_ni && !gw_ni)
      assert_gw_all_R2: assert (&be_o);
    if (rst_ni && gw_ni && (bwe_ni || (&bsel_ni)))
      assert_no_write_R3: assert (be_o == '0);
  end
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic [BYTES-1:0]        be_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (be_i[b]) lane_mem[wr_addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr_i];
  end
endmodule

// File: rtl/ssram_rd_path.sv
module ssram_rd_path
  import ssram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              pipe_i,
  input  logic              oe_ni,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  cmd_e              st1_q, st2_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] out_q;
  logic              flow_drv, pipe_drv, drv_raw;
  logic [DATA_W-1:0] data_sel;

  // st2_q carries deselects as deep as reads (dual-cycle deselect)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st1_q  <= CMD_IDLE;
      st2_q  <= CMD_IDLE;
      addr_q <= '0;
      out_q  <= '0;
    end else begin
      st1_q <= cmd_i;
      st2_q <= sleep_i ? CMD_IDLE : st1_q;
      if (cmd_i == CMD_RD) addr_q <= addr_i;
      if (st1_q == CMD_RD) out_q <= arr_data_i;
    end
  end

  assign rd_addr_o = addr_q;
  assign flow_drv  = (st1_q == CMD_RD) || ((st1_q == CMD_IDLE) && (st2_q == CMD_RD));
  assign pipe_drv  = (st2_q == CMD_RD);
  assign drv_raw   = pipe_i ? pipe_drv : flow_drv;
  // flow-through: live array word on a read slot, held register on the hold slot
  assign data_sel  = (!pipe_i && (st1_q == CMD_RD)) ? arr_data_i : out_q;
  assign drive_o   = drv_raw && !oe_ni && !sleep_i;
  assign rdata_o   = drive_o ? data_sel : '0;

  assert_flow_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RD) |=> (pipe_i || drv_raw));

  assert_pipe_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == CMD_RD) && pipe_i) ##1 (pipe_i && !sleep_i) |=> (drv_raw || !pipe_i));

  assert_dcd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RD) ##1 ((cmd_i == CMD_IDLE) && !sleep_i) |=> drv_raw);

  assert_dcd_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RD) ##1 ((cmd_i == CMD_IDLE) && !sleep_i) ##1 (cmd_i != CMD_RD)
    |=> !drv_raw);

  assert_wr_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_WR) |=> (pipe_i || !drv_raw));
endmodule

// File: rtl/ssram_datapath.sv
module ssram_datapath
  import ssram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_ni,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [BYTES-1:0]        bsel_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  input  logic                    pipe_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o,
  output logic                    drive_o
);
  localparam int unsigned DATA_W = BYTES * BYTE_W;

  cmd_e              cmd;
  logic [BYTES-1:0]  be;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] arr_data;

  ssram_wr_decode #(.BYTES(BYTES)) u_dec (
    .rst_ni  (rst_ni),
    .en_ni   (en_ni),
    .gw_ni   (gw_ni),
    .bwe_ni  (bwe_ni),
    .bsel_ni (bsel_ni),
    .sleep_i (sleep_i),
    .cmd_o   (cmd),
    .be_o    (be)
  );

  ssram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk_i     (clk_i),
    .be_i      (be),
    .wr_addr_i (addr_i),
    .wdata_i   (wdata_i),
    .rd_addr_i (rd_addr),
    .rdata_o   (arr_data)
  );

  ssram_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_i    (sleep_i),
    .pipe_i     (pipe_i),
    .oe_ni      (oe_ni),
    .cmd_i      (cmd),
    .addr_i     (addr_i),
    .rd_addr_o  (rd_addr),
    .arr_data_i (arr_data),
    .rdata_o    (rdata_o),
    .drive_o    (drive_o)
  );

  assert_sleep_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (be == '0));
endmodule

// File: tb/ssram_datapath_test.sv
module ssram_datapath_test;
  typedef struct packed {
    logic        pipe;
    logic        en_n;
    logic        gw_n;
    logic        bwe_n;
    logic [1:0]  bsel_n;
    logic [5:0]  addr;
    logic [15:0] wd;
    logic        drv;
    logic [15:0] dat;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,2'b11,6'd1,16'hA1B2,1'b0,16'h0000}, // 0  R2 global write
    '{1'b0,1'b0,1'b1,1'b0,2'b10,6'd1,16'hFF34,1'b0,16'h0000}, // 1  R1 byte0 only
    '{1'b0,1'b0,1'b0,1'b0,2'b01,6'd2,16'h5566,1'b0,16'h0000}, // 2  R2 gw overrides bytes
    '{1'b0,1'b0,1'b1,1'b0,2'b11,6'd1,16'h0000,1'b1,16'hA134}, // 3  R3 R4 R1 read
    '{1'b0,1'b0,1'b1,1'b1,2'b11,6'd2,16'h0000,1'b1,16'h5566}, // 4  R11
    '{1'b0,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b1,16'h5566}, // 5  R6 hold
    '{1'b0,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b0,16'h0000}, // 6  R6 off
    '{1'b0,1'b0,1'b0,1'b1,2'b11,6'd3,16'h0F0F,1'b0,16'h0000}, // 7  R7
    '{1'b0,1'b0,1'b1,1'b1,2'b11,6'd3,16'h0000,1'b1,16'h0F0F}, // 8  R4
    '{1'b0,1'b0,1'b1,1'b0,2'b01,6'd3,16'hAA00,1'b0,16'h0000}, // 9  R1 byte1, R7
    '{1'b0,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b0,16'h0000}, // 10 R7 no hold after write
    '{1'b1,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b0,16'h0000}, // 11
    '{1'b1,1'b0,1'b1,1'b1,2'b11,6'd3,16'h0000,1'b0,16'h0000}, // 12 R5 not yet
    '{1'b1,1'b0,1'b1,1'b1,2'b11,6'd1,16'h0000,1'b1,16'hAA0F}, // 13 R5 R1
    '{1'b1,1'b0,1'b1,1'b1,2'b11,6'd2,16'h0000,1'b1,16'hA134}, // 14 R11
    '{1'b1,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b1,16'h5566}, // 15 R6 hold
    '{1'b1,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b0,16'h0000}, // 16 R6 off
    '{1'b1,1'b0,1'b1,1'b1,2'b11,6'd1,16'h0000,1'b0,16'h0000}, // 17 R5
    '{1'b1,1'b0,1'b0,1'b1,2'b11,6'd1,16'h1234,1'b1,16'hA134}, // 18 R11 old word while writing
    '{1'b1,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b0,16'h0000}, // 19 R7
    '{1'b1,1'b0,1'b1,1'b1,2'b11,6'd1,16'h0000,1'b0,16'h0000}, // 20
    '{1'b1,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b1,16'h1234}, // 21 R11 new word
    '{1'b1,1'b1,1'b1,1'b1,2'b11,6'd0,16'h0000,1'b0,16'h0000}  // 22
  };

  logic        clk = 1'b0;
  logic        rst_ni, en_ni, gw_ni, bwe_ni, pipe_i, oe_ni, sleep_i;
  logic [1:0]  bsel_ni;
  logic [5:0]  addr_i;
  logic [15:0] wdata_i, rdata_o;
  logic        drive_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  ssram_datapath uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni), .gw_ni(gw_ni), .bwe_ni(bwe_ni),
    .bsel_ni(bsel_ni), .addr_i(addr_i), .wdata_i(wdata_i), .pipe_i(pipe_i),
    .oe_ni(oe_ni), .sleep_i(sleep_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic en, input logic gw, input logic bwe, input logic [1:0] bs,
                     input logic [5:0] a, input logic [15:0] d);
    en_ni = en; gw_ni = gw; bwe_ni = bwe; bsel_ni = bs; addr_i = a; wdata_i = d;
  endtask

  task automatic step;
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; pipe_i = 1'b0; oe_ni = 1'b0; sleep_i = 1'b0;
    cmd(1'b1, 1'b1, 1'b1, 2'b11, 6'd0, 16'h0);
    #25;
    chk("R10 reset drive", 32'(drive_o), 32'd0);
    chk("R10 reset data", 32'(rdata_o), 32'd0);
    #10 rst_ni = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      pipe_i = VEC[i].pipe;
      cmd(VEC[i].en_n, VEC[i].gw_n, VEC[i].bwe_n, VEC[i].bsel_n, VEC[i].addr, VEC[i].wd);
      step();
      chk($sformatf("table row %0d drive", i), 32'(drive_o), 32'(VEC[i].drv));
      chk($sformatf("table row %0d data", i), 32'(rdata_o), 32'(VEC[i].dat));
    end

    // R8: asynchronous output enable on a driven flow-through beat
    pipe_i = 1'b0;
    cmd(1'b0, 1'b1, 1'b1, 2'b11, 6'd2, 16'h0);
    step();
    chk("R4 flow read before oe", 32'(rdata_o), 32'h5566);
    oe_ni = 1'b1;
    #1;
    chk("R8 oe off drive", 32'(drive_o), 32'd0);
    chk("R8 oe off data", 32'(rdata_o), 32'd0);
    oe_ni = 1'b0;
    #1;
    chk("R8 oe back data", 32'(rdata_o), 32'h5566);

    cmd(1'b1, 1'b1, 1'b1, 2'b11, 6'd0, 16'h0);
    step();
    step();
    chk("R6 flow drained", 32'(drive_o), 32'd0);

    // R9: sleep mid-beat, write attempt while asleep, resume
    cmd(1'b0, 1'b1, 1'b1, 2'b11, 6'd2, 16'h0);
    step();
    chk("R9 read before sleep", 32'(drive_o), 32'd1);
    sleep_i = 1'b1;
    #1;
    chk("R9 sleep drops drive", 32'(drive_o), 32'd0);
    cmd(1'b0, 1'b0, 1'b0, 2'b00, 6'd1, 16'hFFFF);
    step();
    chk("R9 no drive asleep", 32'(drive_o), 32'd0);
    cmd(1'b1, 1'b1, 1'b1, 2'b11, 6'd0, 16'h0);
    step();
    sleep_i = 1'b0;
    cmd(1'b0, 1'b1, 1'b1, 2'b11, 6'd1, 16'h0);
    step();
    chk("R9 first edge read drive", 32'(drive_o), 32'd1);
    chk("R9 data retained, write blocked", 32'(rdata_o), 32'h1234);

    rst_ni = 1'b0;
    #1;
    chk("R10 reset mid run", 32'(drive_o), 32'd0);
    finish_run();
  end
endmodule